// File: doc/BRIEF.md
# Padded-Pitch Tile Transpose Buffer

This block transposes a square tile of T by T words. The tile arrives one row per beat on a valid/ready stream. Each input beat carries all T words of one row. The block then presents the tile one column per beat, so each output beat is one row of the transposed tile. Global matrix addressing and the swap of tile origins are done outside the block.

Storage is split into T banks. Each bank has one write port and one read port. Element (i,j) sits at linear word i*(T+1)+j, which leaves one spare word at the end of every row. Its bank is therefore (i+j) mod T. Without the spare word, a whole column would land in bank j. With it, both a full row and a full column touch every bank exactly once, so each can be moved in a single cycle.

There are two tile buffers used in turn (ping-pong), so one tile can be written while the previous one is read out. Each buffer is governed by a two-state machine:
- BS_FREE moves to BS_LOADED when its last row is accepted.
- BS_LOADED moves back to BS_FREE when its last column is loaded into the output register.

A full buffer is the synchronisation point between the write phase and the read phase. T is a parameter, with a default of 32. With T set to 16 the pitch becomes 17 words and the bank count becomes 16.

Top module: `tile_transpose_buf`

## Requirements
- R1: After reset, in_ready is 1 and out_valid is 0.
- R2: Input lane j, in_data[j*W +: W], of the r-th accepted beat of a tile is element (r,j). Output lane i, out_data[i*W +: W], of the c-th emitted beat of that tile equals element (i,c).
- R3: Each tile produces exactly T output beats, with c rising from 0 to T-1. Tiles leave in the order they arrived.
- R4: A row write places element (i,j) in bank (i+j) mod T, at word floor((i*(T+1)+j)/T) of its buffer, so the T words of a row go to T distinct banks.
- R5: A column read fetches its T words from T distinct banks in one cycle.
- R6: in_ready is 1 exactly when the buffer now being written is in BS_FREE. Rows of a new tile are accepted while the other buffer drains. A beat offered while in_ready is 0 writes nothing.
- R7: While both buffers are in BS_LOADED, in_ready is 0. It returns to 1 in the cycle after the last column of the older tile is loaded into the output register.
- R8: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data holds its value.
- R9: The first column of a tile appears on out_valid at the clock edge after the edge that accepted its last row. With out_ready held at 1, the remaining columns follow on consecutive edges. A second complete tile follows the first with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An input row is offered |
| in_ready | output | 1 | The block accepts a row this cycle |
| in_data | input | T*W | One tile row, lane j holds column j |
| out_valid | output | 1 | An output column is presented |
| out_ready | input | 1 | Downstream takes the output beat |
| out_data | output | T*W | One tile column, lane i holds row i |

## Verification
Two functions can fall in the same cycle: a row write into one buffer, and a column read of the other buffer into the output register. In the tightest case, the last row of one tile and the last column of the other tile land on the same edge. Continuous streaming provokes this, and so does a long stretch of random in_valid and out_ready. A stretch with out_ready held low forces both buffers full. A behavioural reference model of the tile queue predicts in_ready, out_valid and out_data on every cycle, and each cycle is judged against it.

// File: rtl/tt_pkg.sv
package tt_pkg;
    typedef enum logic {BS_FREE, BS_LOADED} buf_state_e;

    function automatic int unsigned bank_of(int unsigned row, int unsigned col, int unsigned t);
        return (row + col) % t;
    endfunction

    function automatic int unsigned word_of(int unsigned row, int unsigned col, int unsigned t);
        return (row * (t + 1) + col) / t;
    endfunction
endpackage

// File: rtl/tt_bank.sv
module tt_bank #(
    parameter int W     = 32,
    parameter int DEPTH = 66,
    parameter int AW    = 7
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/tt_seq.sv
module tt_seq #(
    parameter int LEN = 32,
    localparam int CW = (LEN > 1) ? $clog2(LEN) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [CW-1:0] idx,
    output logic          sel,
    output logic          last
);
    assign last = (idx == CW'(LEN - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= '0;
            sel <= 1'b0;
        end else if (step) begin
            if (last) begin
                idx <= '0;
                sel <= ~sel;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tt_buf_fsm.sv
module tt_buf_fsm
    import tt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fill_done,
    input  logic drain_done,
    output logic loaded
);
    buf_state_e st, st_nx;

    always_comb begin
        st_nx = st;
        unique case (st)
            BS_FREE:   if (fill_done)  st_nx = BS_LOADED;
            BS_LOADED: if (drain_done) st_nx = BS_FREE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= BS_FREE;
        else        st <= st_nx;
    end

    always_comb begin
        loaded = (st == BS_LOADED);
    end

    // R6: a tile is only completed into a free buffer
    assert_fill_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |-> st == BS_FREE);
    // R6: a buffer is only drained once it holds a whole tile
    assert_drain_loaded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        drain_done |-> st == BS_LOADED);
endmodule

// File: rtl/tile_transpose_buf.sv
module tile_transpose_buf
    import tt_pkg::*;
#(
    parameter int T = 32,
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    output logic           in_ready,
    input  logic [T*W-1:0] in_data,
    output logic           out_valid,
    input  logic           out_ready,
    output logic [T*W-1:0] out_data
);
    localparam int IW     = (T > 1) ? $clog2(T) : 1;
    localparam int BDEPTH = T + 1;
    localparam int MDEPTH = 2 * BDEPTH;
    localparam int AW     = $clog2(MDEPTH);

    logic [IW-1:0] wr_row, rd_col;
    logic          wr_sel, rd_sel, wr_last, rd_last;
    logic [1:0]    loaded, fill_done, drain_done;
    logic          in_fire, rd_go;

    // per-lane bank and word selection
    logic [IW-1:0] wl_bank [T];
    logic [AW-1:0] wl_addr [T];
    logic [IW-1:0] rl_bank [T];
    logic [AW-1:0] rl_addr [T];
    // per-bank port signals
    logic [AW-1:0] b_waddr [T];
    logic [W-1:0]  b_wdata [T];
    logic [AW-1:0] b_raddr [T];
    logic [W-1:0]  b_rdata [T];
    logic [T*W-1:0] col_data;
    logic [T-1:0]  wr_mask, rd_mask;

    assign in_ready = ~loaded[wr_sel];
    assign in_fire  = in_valid & in_ready;
    assign rd_go    = loaded[rd_sel] & (~out_valid | out_ready);

    tt_seq #(.LEN(T)) u_wr_seq (
        .clk(clk), .rst_n(rst_n), .step(in_fire),
        .idx(wr_row), .sel(wr_sel), .last(wr_last)
    );

    tt_seq #(.LEN(T)) u_rd_seq (
        .clk(clk), .rst_n(rst_n), .step(rd_go),
        .idx(rd_col), .sel(rd_sel), .last(rd_last)
    );

    generate
        for (genvar b = 0; b < 2; b++) begin : g_buf
            assign fill_done[b]  = in_fire & wr_last & (wr_sel == 1'(b));
            assign drain_done[b] = rd_go & rd_last & (rd_sel == 1'(b));
            tt_buf_fsm u_fsm (
                .clk(clk), .rst_n(rst_n),
                .fill_done(fill_done[b]), .drain_done(drain_done[b]),
                .loaded(loaded[b])
            );
        end
    endgenerate

    // lane-side mapping: row i, column j -> bank (i+j) mod T, padded word
    always_comb begin
        for (int k = 0; k < T; k++) begin
            wl_bank[k] = IW'(bank_of(int'(wr_row), k, T));
            wl_addr[k] = AW'((wr_sel ? BDEPTH : 0) + word_of(int'(wr_row), k, T));
            rl_bank[k] = IW'(bank_of(k, int'(rd_col), T));
            rl_addr[k] = AW'((rd_sel ? BDEPTH : 0) + word_of(k, int'(rd_col), T));
        end
    end

    // crossbar from lanes to banks
    always_comb begin
        wr_mask = '0;
        rd_mask = '0;
        for (int b = 0; b < T; b++) begin
            b_waddr[b] = '0;
            b_wdata[b] = '0;
            b_raddr[b] = '0;
        end
        for (int k = 0; k < T; k++) begin
            wr_mask[wl_bank[k]] = 1'b1;
            rd_mask[rl_bank[k]] = 1'b1;
            b_waddr[wl_bank[k]] = wl_addr[k];
            b_wdata[wl_bank[k]] = in_data[k*W +: W];
            b_raddr[rl_bank[k]] = rl_addr[k];
        end
    end

    generate
        for (genvar b = 0; b < T; b++) begin : g_bank
            tt_bank #(.W(W), .DEPTH(MDEPTH), .AW(AW)) u_bank (
                .clk(clk), .we(in_fire),
                .waddr(b_waddr[b]), .wdata(b_wdata[b]),
                .raddr(b_raddr[b]), .rdata(b_rdata[b])
            );
        end
    endgenerate

    always_comb begin
        for (int k = 0; k < T; k++) col_data[k*W +: W] = b_rdata[rl_bank[k]];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (rd_go) begin
            out_valid <= 1'b1;
            out_data  <= col_data;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // R4: an accepted row spreads over every bank
    assert_row_banks_distinct_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_fire |-> $countones(wr_mask) == T);
    // R5: a column fetch hits every bank once
    assert_col_banks_distinct_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_go |-> $countones(rd_mask) == T);
    // R8: a stalled output beat is held
    assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));
    // R7: both buffers loaded blocks input
    assert_full_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (&loaded) |-> !in_ready);
endmodule

// File: tb/tile_transpose_buf_test.sv
module tile_transpose_buf_test;
    localparam int T = 32;
    localparam int W = 32;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic           in_ready;
    logic [T*W-1:0] in_data = '0;
    logic           out_valid;
    logic           out_ready = 1'b0;
    logic [T*W-1:0] out_data;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    always #5 clk = ~clk;

    tile_transpose_buf #(.T(T), .W(W)) uut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    // reference model: two tile slots handled as a queue
    logic [W-1:0]   mtile [2][T][T];
    bit             mfull [2];
    int             mwsel, mrsel, mrow, mcol;
    bit             mov;
    logic [T*W-1:0] mod;

    task automatic model_step();
        bit fire, go;
        fire = in_valid && !mfull[mwsel];
        go   = mfull[mrsel] && (!mov || out_ready);
        if (go) begin
            mov = 1;
            for (int i = 0; i < T; i++) mod[i*W +: W] = mtile[mrsel][i][mcol];
            if (mcol == T-1) begin
                mfull[mrsel] = 0;
                mrsel = 1 - mrsel;
                mcol = 0;
            end else mcol++;
        end else if (out_ready) mov = 0;
        if (fire) begin
            for (int j = 0; j < T; j++) mtile[mwsel][mrow][j] = in_data[j*W +: W];
            if (mrow == T-1) begin
                mfull[mwsel] = 1;
                mwsel = 1 - mwsel;
                mrow = 0;
            end else mrow++;
        end
    endtask

    task automatic compare();
        vectors++;
        if (in_ready !== !mfull[mwsel]) begin
            errors++;
            $display("FAIL R6 R7 in_ready act=%0b exp=%0b", in_ready, !mfull[mwsel]);
        end
        vectors++;
        if (out_valid !== mov) begin
            errors++;
            $display("FAIL R3 R9 out_valid act=%0b exp=%0b", out_valid, mov);
        end
        if (mov) begin
            vectors++;
            if (out_data !== mod) begin
                errors++;
                $display("FAIL R2 R3 R4 R5 R8 out_data act=%h exp=%h", out_data, mod);
            end
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        mfull[0] = 0; mfull[1] = 0;
        mwsel = 0; mrsel = 0; mrow = 0; mcol = 0; mov = 0; mod = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        vectors++;
        if (in_ready !== 1'b1 || out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset act=%0b%0b exp=10", in_ready, out_valid);
        end
        rst_n = 1'b1;
        for (int n = 0; n < 3600; n++) begin
            @(negedge clk);
            compare();
            if (n < 200) begin
                in_valid = 1'b1; out_ready = 1'b1;          // streaming, R9
            end else if (n < 400) begin
                in_valid = 1'b1; out_ready = 1'b0;          // both full, R7 R8
            end else if (n < 3400) begin
                in_valid  = ($urandom % 10) < 7;            // mixed, R6
                out_ready = ($urandom % 10) < 6;
            end else begin
                in_valid = 1'b0; out_ready = 1'b1;          // drain
            end
            for (int j = 0; j < T; j++) in_data[j*W +: W] = W'($urandom);
            if (n == 399) begin
                // R7: both buffers hold tiles, input must be blocked
                vectors++;
                if (in_ready !== 1'b0) begin
                    errors++;
                    $display("FAIL R7 blocked act=%0b exp=0", in_ready);
                end
            end
            model_step();
        end
        @(negedge clk);
        compare();
        finish_run();
    end
endmodule